// File: doc/BRIEF.md
# Amplifier Power-Up Initialization Sequencer

This block runs on the host side of a multichannel digital audio amplifier and takes it from power-on to active playback. It drives the amplifier's power-down, mute and reset pins and times every mandatory wait by counting cycles of a free-running system clock. Register writes go out as requests on a request/acknowledge port to an external I2C master. Each request carries one address and one data byte.

The bring-up runs in this order. The pins stay quiet until supply is good. Then comes a settle delay on stable audio clocks, followed by the reset release and the post-reset delay. An oscillator trim write follows, then a lock wait. The signal-processing registers are written next, then the general registers, both from a computed internal list. The final write releases all-channel shutdown.

A reconfiguration request issued while done re-enters the sequence part-way. The block first puts the amplifier back into all-channel shutdown, waits out the shutdown interval and waits for stable clocks. It then repeats the lock wait and the whole register list, without the trim write. A NACK on any write parks the block in an error state.

Top module: `amp_init_seq`

## Requirements
- R1: Out of reset and while `pwr_good_i` is low, `pdn_o`, `mute_o`, `reset_o`, `wr_req_o`, `done_o` and `err_o` are all low.
- R2: The cycle after `pwr_good_i` is first sampled high, `pdn_o` and `mute_o` are high and `reset_o` is low. `pdn_o` never falls again before reset.
- R3: `reset_o` rises exactly `T_SETTLE_US*CLKS_PER_US` cycles after the first clock edge that samples `clk_stable_i` high in the clock-wait state.
- R4: No write is requested while `reset_o` is low. The first request appears exactly `T_RESET_US*CLKS_PER_US` cycles after `reset_o` rises, and it writes data 0x00 to address 0x1B.
- R5: After the trim write is acknowledged, the lock wait lasts `T_LOCK_US*CLKS_PER_US` cycles before the next request, measured from the cycle the trim request drops.
- R6: The register list is written in this order: 0x21; 0x23–0x24; 0x29–0x38; 0x3A–0x46; 0x50; then 0x04 and 0x07–0x0E. Each entry's data byte is its address XOR 0x5A.
- R7: The last write stores `SHDN_BASE` with bit 6 cleared (0x00 by default) to address 0x05. The cycle after its acknowledge, `done_o` is high and `mute_o` is low.
- R8: A `reconfig_i` pulse while done starts a write of `SHDN_BASE` with bit 6 set (0x40) to address 0x05. After its acknowledge comes a wait of `T_SHDN_US*CLKS_PER_US` cycles, then one clock-stable check cycle, then the lock wait. The full register list and the exit write follow, with no trim write. Throughout, `pdn_o` and `reset_o` stay high and `mute_o` keeps its value. The next request follows the drop of the entry request after `T_SHDN+T_LOCK+1` cycles.
- R9: `wr_req_o` stays high with stable `wr_addr_o`/`wr_data_o` until `wr_ack_i` or `wr_nack_i`. Each list entry is requested exactly once.
- R10: A `wr_nack_i` moves the block to an error state. From the next cycle until reset, `err_o` is high and `wr_req_o` and `done_o` are low.
- R11: If `clk_stable_i` is low during the settle, post-reset or lock wait, the block returns to clock wait: `reset_o` is low and no request is raised the next cycle. The R3 timing applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supplies are stable |
| clk_stable_i | input | 1 | Audio clocks are stable |
| reconfig_i | input | 1 | Reconfiguration request, sampled while done |
| pdn_o | output | 1 | Amplifier power-down pin, high = active |
| mute_o | output | 1 | Amplifier mute pin |
| reset_o | output | 1 | Amplifier reset pin, high = released |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | 8 | Register address |
| wr_data_o | output | 8 | Register data |
| wr_ack_i | input | 1 | Write completed |
| wr_nack_i | input | 1 | Write refused |
| done_o | output | 1 | Sequence complete, amplifier active |
| err_o | output | 1 | Sequence aborted on NACK |

## Verification
The bench builds the block with `CLKS_PER_US=1` and leaves every wait duration at its default. The 100 µs settle, 13.5 ms post-reset delay, 50 ms lock wait and 2 ms shutdown wait therefore become exact cycle counts of 100, 13500, 50000 and 2000. Both the full bring-up and a reconfiguration pass fit in one run, and each interval is checked to the cycle. Varying acknowledge latency exercises request holding. A clock drop in the post-reset wait and a NACK on the shutdown-entry write cover the abort paths.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_CLK_WAIT,
    ST_SETTLE,
    ST_RST_WAIT,
    ST_TRIM_WR,
    ST_LOCK_WAIT,
    ST_CFG_WR,
    ST_EXIT_WR,
    ST_DONE,
    ST_RC_ENTER_WR,
    ST_RC_SHDN_WAIT,
    ST_RC_CLK_WAIT,
    ST_ERR
  } seq_state_e;

  localparam logic [7:0] OSC_TRIM_ADDR = 8'h1B;
  localparam logic [7:0] OSC_TRIM_VAL  = 8'h00;
  localparam logic [7:0] SHDN_ADDR     = 8'h05;
  localparam int unsigned SHDN_BIT     = 6;
  localparam logic [7:0] CFG_DATA_XOR  = 8'h5A;
  localparam int unsigned CFG_LEN      = 42;

  // DSP block first (entries 0..32), general registers after (33..41)
  function automatic logic [7:0] cfg_addr(input int unsigned i);
    if (i == 0)  return 8'h21;
    if (i < 3)   return 8'(32'h23 + i - 1);
    if (i < 19)  return 8'(32'h29 + i - 3);
    if (i < 32)  return 8'(32'h3A + i - 19);
    if (i == 32) return 8'h50;
    if (i == 33) return 8'h04;
    return 8'(32'h07 + i - 34);
  endfunction

endpackage

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  assign hit_o = (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/seq_cfg_list.sv
module seq_cfg_list
  import amp_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       addr_o,
  output logic [7:0]       data_o,
  output logic             last_o
);
  assign addr_o = cfg_addr(32'(idx_i));
  assign data_o = addr_o ^ CFG_DATA_XOR;
  assign last_o = (32'(idx_i) == CFG_LEN - 1);
endmodule

// File: rtl/amp_init_seq.sv
module amp_init_seq
  import amp_seq_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 50,
  parameter int unsigned T_SETTLE_US = 100,
  parameter int unsigned T_RESET_US  = 13500,
  parameter int unsigned T_LOCK_US   = 50000,
  parameter int unsigned T_SHDN_US   = 2000,
  parameter logic [7:0]  SHDN_BASE   = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       clk_stable_i,
  input  logic       reconfig_i,
  output logic       pdn_o,
  output logic       mute_o,
  output logic       reset_o,
  output logic       wr_req_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  input  logic       wr_ack_i,
  input  logic       wr_nack_i,
  output logic       done_o,
  output logic       err_o
);
  localparam int unsigned CYC_SETTLE = T_SETTLE_US * CLKS_PER_US;
  localparam int unsigned CYC_RESET  = T_RESET_US * CLKS_PER_US;
  localparam int unsigned CYC_LOCK   = T_LOCK_US * CLKS_PER_US;
  localparam int unsigned CYC_SHDN   = T_SHDN_US * CLKS_PER_US;
  localparam int unsigned CYC_MAX_A  = (CYC_SETTLE > CYC_RESET) ? CYC_SETTLE : CYC_RESET;
  localparam int unsigned CYC_MAX_B  = (CYC_LOCK > CYC_SHDN) ? CYC_LOCK : CYC_SHDN;
  localparam int unsigned CYC_MAX    = (CYC_MAX_A > CYC_MAX_B) ? CYC_MAX_A : CYC_MAX_B;
  localparam int unsigned CNT_W      = $clog2(CYC_MAX + 1);
  localparam int unsigned IDX_W      = $clog2(CFG_LEN);
  localparam logic [7:0]  SHDN_ON    = SHDN_BASE | (8'h01 << SHDN_BIT);
  localparam logic [7:0]  SHDN_OFF   = SHDN_BASE & ~(8'h01 << SHDN_BIT);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             mute_q;
  logic [CNT_W-1:0] limit;
  logic             tmr_clear, tmr_hit;
  logic [7:0]       rom_addr, rom_data;
  logic             rom_last;

  seq_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .limit_i (limit),
    .hit_o   (tmr_hit)
  );

  seq_cfg_list #(.IDX_W(IDX_W)) u_cfg (
    .idx_i  (idx_q),
    .addr_o (rom_addr),
    .data_o (rom_data),
    .last_o (rom_last)
  );

  always_comb begin
    unique case (state_q)
      ST_SETTLE:       limit = CNT_W'(CYC_SETTLE);
      ST_RST_WAIT:     limit = CNT_W'(CYC_RESET);
      ST_LOCK_WAIT:    limit = CNT_W'(CYC_LOCK);
      ST_RC_SHDN_WAIT: limit = CNT_W'(CYC_SHDN);
      default:         limit = CNT_W'(CYC_MAX);
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:      if (pwr_good_i) state_d = ST_CLK_WAIT;
      ST_CLK_WAIT: if (clk_stable_i) state_d = ST_SETTLE;
      ST_SETTLE: begin
        if (!clk_stable_i) state_d = ST_CLK_WAIT;
        else if (tmr_hit)  state_d = ST_RST_WAIT;
      end
      ST_RST_WAIT: begin
        if (!clk_stable_i) state_d = ST_CLK_WAIT;
        else if (tmr_hit)  state_d = ST_TRIM_WR;
      end
      ST_TRIM_WR: begin
        if (wr_nack_i)     state_d = ST_ERR;
        else if (wr_ack_i) state_d = ST_LOCK_WAIT;
      end
      ST_LOCK_WAIT: begin
        if (!clk_stable_i) state_d = ST_CLK_WAIT;
        else if (tmr_hit)  state_d = ST_CFG_WR;
      end
      ST_CFG_WR: begin
        if (wr_nack_i)                 state_d = ST_ERR;
        else if (wr_ack_i && rom_last) state_d = ST_EXIT_WR;
      end
      ST_EXIT_WR: begin
        if (wr_nack_i)     state_d = ST_ERR;
        else if (wr_ack_i) state_d = ST_DONE;
      end
      ST_DONE: if (reconfig_i) state_d = ST_RC_ENTER_WR;
      ST_RC_ENTER_WR: begin
        if (wr_nack_i)     state_d = ST_ERR;
        else if (wr_ack_i) state_d = ST_RC_SHDN_WAIT;
      end
      ST_RC_SHDN_WAIT: if (tmr_hit) state_d = ST_RC_CLK_WAIT;
      ST_RC_CLK_WAIT:  if (clk_stable_i) state_d = ST_LOCK_WAIT;
      ST_ERR:          state_d = ST_ERR;
      default:         state_d = ST_ERR;
    endcase
  end

  assign tmr_clear = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      idx_q   <= '0;
      mute_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOCK_WAIT) idx_q <= '0;
      else if (state_q == ST_CFG_WR && wr_ack_i && !rom_last) idx_q <= idx_q + IDX_W'(1);
      // mute set on power-good, released at done, otherwise held
      if (state_q == ST_OFF && state_d == ST_CLK_WAIT) mute_q <= 1'b1;
      else if (state_d == ST_DONE)                      mute_q <= 1'b0;
    end
  end

  always_comb begin
    wr_req_o  = 1'b1;
    wr_addr_o = 8'h00;
    wr_data_o = 8'h00;
    unique case (state_q)
      ST_TRIM_WR:     begin wr_addr_o = OSC_TRIM_ADDR; wr_data_o = OSC_TRIM_VAL; end
      ST_CFG_WR:      begin wr_addr_o = rom_addr;      wr_data_o = rom_data;     end
      ST_EXIT_WR:     begin wr_addr_o = SHDN_ADDR;     wr_data_o = SHDN_OFF;     end
      ST_RC_ENTER_WR: begin wr_addr_o = SHDN_ADDR;     wr_data_o = SHDN_ON;      end
      default:        wr_req_o = 1'b0;
    endcase
  end

  assign pdn_o   = (state_q != ST_OFF);
  assign reset_o = !(state_q inside {ST_OFF, ST_CLK_WAIT, ST_SETTLE});
  assign mute_o  = mute_q;
  assign done_o  = (state_q == ST_DONE);
  assign err_o   = (state_q == ST_ERR);
endmodule

// File: rtl/amp_init_seq_chk.sv
module amp_init_seq_chk
  import amp_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_stable_i,
  input logic       pdn_o,
  input logic       mute_o,
  input logic       reset_o,
  input logic       wr_req_o,
  input logic [7:0] wr_addr_o,
  input logic [7:0] wr_data_o,
  input logic       wr_ack_i,
  input logic       wr_nack_i,
  input logic       done_o,
  input logic       err_o,
  input seq_state_e state_q
);
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_o |-> !mute_o && !reset_o && !wr_req_o && !done_o && !err_o); // R1

  AST_PDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_o |=> pdn_o); // R2

  AST_WR_NEEDS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> reset_o && pdn_o); // R4

  AST_DONE_UNMUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mute_o && !wr_req_o); // R7

  AST_RC_MUTE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_addr_o == SHDN_ADDR && wr_data_o[SHDN_BIT]) |=> $stable(mute_o) && reset_o); // R8

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i && !wr_nack_i) |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o && !wr_req_o && !done_o); // R10

  AST_CLK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q inside {ST_SETTLE, ST_RST_WAIT, ST_LOCK_WAIT}) && !clk_stable_i) |=> !reset_o && !wr_req_o); // R11
endmodule

bind amp_init_seq amp_init_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_stable_i (clk_stable_i),
  .pdn_o        (pdn_o),
  .mute_o       (mute_o),
  .reset_o      (reset_o),
  .wr_req_o     (wr_req_o),
  .wr_addr_o    (wr_addr_o),
  .wr_data_o    (wr_data_o),
  .wr_ack_i     (wr_ack_i),
  .wr_nack_i    (wr_nack_i),
  .done_o       (done_o),
  .err_o        (err_o),
  .state_q      (state_q)
);

// File: tb/amp_init_seq_tb_top.sv
module amp_init_seq_tb_top;
  localparam int N_SET  = 100;
  localparam int N_RST  = 13500;
  localparam int N_LOCK = 50000;
  localparam int N_SHDN = 2000;

  typedef struct {
    logic [7:0] a;
    logic [7:0] d;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, pwr_good, clk_ok, reconfig, ack, nack;
  logic pdn, mute, rst_pin, req, done, err;
  logic [7:0] addr, data;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  bit   nack_mode = 1'b0;
  exp_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  amp_init_seq #(.CLKS_PER_US(1)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pwr_good_i   (pwr_good),
    .clk_stable_i (clk_ok),
    .reconfig_i   (reconfig),
    .pdn_o        (pdn),
    .mute_o       (mute),
    .reset_o      (rst_pin),
    .wr_req_o     (req),
    .wr_addr_o    (addr),
    .wr_data_o    (data),
    .wr_ack_i     (ack),
    .wr_nack_i    (nack),
    .done_o       (done),
    .err_o        (err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // R6 list, then R7 exit write
  task automatic push_list(input bit with_trim);
    if (with_trim) push(8'h1B, 8'h00, "R4");
    push(8'h21, 8'h21 ^ 8'h5A, "R6");
    for (int a = 8'h23; a <= 8'h24; a++) push(8'(a), 8'(a) ^ 8'h5A, "R6");
    for (int a = 8'h29; a <= 8'h38; a++) push(8'(a), 8'(a) ^ 8'h5A, "R6");
    for (int a = 8'h3A; a <= 8'h46; a++) push(8'(a), 8'(a) ^ 8'h5A, "R6");
    push(8'h50, 8'h50 ^ 8'h5A, "R6");
    push(8'h04, 8'h04 ^ 8'h5A, "R6");
    for (int a = 8'h07; a <= 8'h0E; a++) push(8'(a), 8'(a) ^ 8'h5A, "R6");
    push(8'h05, 8'h00, "R7");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor / responder: pops expected writes, varies ack latency
  int         n_req = 0;
  int         hold = 0;
  bit         pending = 1'b0;
  logic [7:0] held_a, held_d;

  always @(negedge clk) begin
    if (ack || nack) begin
      ack  <= 1'b0;
      nack <= 1'b0;
    end else if (req) begin
      if (!pending) begin
        pending = 1'b1;
        hold    = 0;
        held_a  = addr;
        held_d  = data;
        n_req++;
      end else begin
        chk(addr == held_a && data == held_d, "R9 request unstable", {addr, data}, {held_a, held_d});
      end
      if (hold < (n_req % 3)) begin
        hold++;
      end else begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected request", {addr, data}, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(addr == e.a && data == e.d, e.tag, {addr, data}, {e.a, e.d});
        end
        if (nack_mode) nack <= 1'b1;
        else           ack  <= 1'b1;
        pending = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int t0;
    rst_n = 1'b0; pwr_good = 1'b0; clk_ok = 1'b0; reconfig = 1'b0;
    ack = 1'b0; nack = 1'b0;
    repeat (3) @(negedge clk);
    chk({pdn, mute, rst_pin, req, done, err} == 6'b0, "R1 reset state",
        {pdn, mute, rst_pin, req, done, err}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk({pdn, mute, rst_pin, req, done, err} == 6'b0, "R1 no power-good",
        {pdn, mute, rst_pin, req, done, err}, 0);

    pwr_good = 1'b1;
    @(negedge clk);
    chk({pdn, mute, rst_pin} == 3'b110, "R2 pins after power-good", {pdn, mute, rst_pin}, 3'b110);
    push_list(1'b1);
    repeat (5) @(negedge clk);

    clk_ok = 1'b1; t0 = cyc;
    while (!rst_pin) @(negedge clk);
    chk(cyc - t0 == N_SET + 1, "R3 settle delay", cyc - t0, N_SET + 1);

    // R11: drop clocks during post-reset wait
    repeat (100) @(negedge clk);
    clk_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rst_pin && !req && pdn, "R11 reset dropped", {rst_pin, req, pdn}, 3'b001);
    repeat (10) @(negedge clk);
    chk(!rst_pin, "R11 reset held in clock wait", rst_pin, 0);
    clk_ok = 1'b1; t0 = cyc;
    while (!rst_pin) @(negedge clk);
    chk(cyc - t0 == N_SET + 1, "R11 settle restarted", cyc - t0, N_SET + 1);

    t0 = cyc;
    while (!req) @(negedge clk);
    chk(cyc - t0 == N_RST, "R4 post-reset wait", cyc - t0, N_RST);
    chk(addr == 8'h1B && data == 8'h00, "R4 trim write", {addr, data}, 16'h1B00);
    while (req) @(negedge clk);
    t0 = cyc;
    while (!req) @(negedge clk);
    chk(cyc - t0 == N_LOCK, "R5 lock wait", cyc - t0, N_LOCK);

    while (!done) @(negedge clk);
    chk(!mute && pdn && rst_pin, "R7 pins at done", {mute, pdn, rst_pin}, 3'b011);
    chk(exp_q.size() == 0, "R6 list complete", exp_q.size(), 0);

    // R8 reconfiguration
    push(8'h05, 8'h40, "R8");
    push_list(1'b0);
    reconfig = 1'b1;
    @(negedge clk);
    reconfig = 1'b0;
    while (!req) @(negedge clk);
    while (req) @(negedge clk);
    t0 = cyc;
    repeat (1000) @(negedge clk);
    chk(pdn && rst_pin && !mute && !done && !req, "R8 pins in shutdown wait",
        {pdn, rst_pin, mute, done, req}, 5'b11000);
    while (!req) @(negedge clk);
    chk(cyc - t0 == N_SHDN + N_LOCK + 1, "R8 shutdown and lock wait", cyc - t0, N_SHDN + N_LOCK + 1);
    while (!done) @(negedge clk);
    chk(!mute && rst_pin, "R8 done again", {mute, rst_pin}, 2'b01);
    chk(exp_q.size() == 0, "R8 list without trim", exp_q.size(), 0);

    // R10 NACK on shutdown entry
    nack_mode = 1'b1;
    push(8'h05, 8'h40, "R8");
    reconfig = 1'b1;
    @(negedge clk);
    reconfig = 1'b0;
    repeat (10) @(negedge clk);
    chk({err, done, req} == 3'b100, "R10 error state", {err, done, req}, 3'b100);
    repeat (50) @(negedge clk);
    chk({err, done, req} == 3'b100, "R10 error sticky", {err, done, req}, 3'b100);
    chk(exp_q.size() == 0, "R10 nacked write seen", exp_q.size(), 0);
    summary();
  end
endmodule